// File: doc/BRIEF.md
# Multi-clock-per-pixel LCD sync generator

This block produces the line sync, frame sync and data-enable window for a 320x240 TFT panel whose pixels reach the panel over a narrow bus. Depending on the bus mode, one pixel takes one, two or three bus clocks. Every horizontal timing value is scaled by that clocks-per-pixel factor. The start of the active window also carries a mode-dependent correction for the pipeline delay of the external serializer.

Alongside the syncs the block gives a downstream serializer three things: a pixel-phase count that says which bus beat of the current pixel is due, the column of the current pixel, and the index of the current line. The mode select is taken only at a frame boundary, or while the generator is idle, so a frame in progress never changes its timing. The reserved mode value keeps every output inactive.

Top module: `lcd_sync_gen`

## Requirements
- R1: Mode select 0 gives 1 clock per pixel with correction 0, mode 1 gives 2 clocks per pixel with correction 3, and mode 2 gives 3 clocks per pixel with correction 5. A line lasts 336 times clocks-per-pixel bus clocks.
- R2: `hsync_n` is driven low (active low) for the first 2 times clocks-per-pixel clocks of every line, and is high for the rest of the line.
- R3: `de` is high for 320 times clocks-per-pixel consecutive clocks. It rises at line position 7 times clocks-per-pixel plus the correction, counted from 0 at the line start, and it is high only on lines 0 to V_VISIBLE-1.
- R4: A frame holds V_VISIBLE+V_BLANK lines (240+4 by default). `vsync_n` is low (active low) only during the first 2 times clocks-per-pixel clocks of line 0, together with `hsync_n`.
- R5: While `de` is high, `pix_phase` counts 0 up to clocks-per-pixel minus 1 and then repeats. `col` starts at 0 and increases by one per pixel. Both read 0 while `de` is low.
- R6: `line` gives the index of the current line, from 0 to V_VISIBLE+V_BLANK-1, and returns to 0 at each frame start.
- R7: A change on `mode` during a frame does not alter that frame's timing. The new mode is used from the first clock of the next frame.
- R8: Mode value 3 keeps `hsync_n` and `vsync_n` high and `de`, `pix_phase`, `col` and `line` at 0. While the generator is idle, the mode select is sampled every clock, so a valid mode starts a frame on the next clock.
- R9: While `en` is low, all outputs are in the inactive state of R8. After `en` rises at a clock edge, the next clock begins line 0 at position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| mode | input | 2 | Bus mode select (0, 1, 2 valid; 3 reserved) |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| de | output | 1 | Active pixel window |
| pix_phase | output | PH_W | Bus beat within the current pixel |
| col | output | COL_W | Pixel column within the active window |
| line | output | LN_W | Current line index |

## Verification
The assertions assume that `en` and `mode` are synchronous to `clk` and that reset is applied before the first checked cycle. The step properties for phase, column and line then describe a generator that either runs freely or is held idle by `en` or by the reserved mode. The stimulus changes `en` and `mode` only on the falling clock edge, after the outputs have been sampled. It runs each of the three modes through a whole frame and changes the mode partway through a frame to show that the change waits for the boundary. The bench uses a short frame (6 visible and 2 blanking lines) so that full frames of all three modes fit within the run.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
   typedef enum logic [1:0] {
      PIX_WIDE = 2'd0,
      PIX_565N = 2'd1,
      PIX_888N = 2'd2,
      PIX_NONE = 2'd3
   } pix_mode_e;

   localparam int MAX_CPP = 3;
endpackage

// File: rtl/lcd_mode_ctrl.sv
module lcd_mode_ctrl
   import lcd_sync_pkg::*;
#(
   parameter int H_TOTAL  = 336,
   parameter int H_ACTIVE = 320,
   parameter int H_SYNC   = 2,
   parameter int H_START  = 7,
   parameter int CORR_X1  = 0,
   parameter int CORR_X2  = 3,
   parameter int CORR_X3  = 5,
   parameter int HC_W     = 10,
   parameter int PH_W     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [1:0]      mode_in,
   input  logic            frame_end,
   output logic            run,
   output logic [PH_W-1:0] cpp_last,
   output logic [HC_W-1:0] h_last,
   output logic [HC_W-1:0] h_sync_w,
   output logic [HC_W-1:0] h_de_beg,
   output logic [HC_W-1:0] h_de_end
);
   pix_mode_e mode_q;
   logic      run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PIX_NONE;
         run_q  <= 1'b0;
      end else if (!en) begin
         run_q  <= 1'b0;
      end else if (!run_q || frame_end) begin
         mode_q <= pix_mode_e'(mode_in);
         run_q  <= (mode_in != PIX_NONE);
      end
   end

   assign run = run_q && en;

   always_comb begin
      int cpp;
      int corr;
      case (mode_q)
         PIX_565N: begin cpp = 2; corr = CORR_X2; end
         PIX_888N: begin cpp = 3; corr = CORR_X3; end
         default:  begin cpp = 1; corr = CORR_X1; end
      endcase
      cpp_last = PH_W'(cpp - 1);
      h_last   = HC_W'(H_TOTAL * cpp - 1);
      h_sync_w = HC_W'(H_SYNC * cpp);
      h_de_beg = HC_W'(H_START * cpp + corr);
      h_de_end = HC_W'(H_START * cpp + corr + H_ACTIVE * cpp);
   end
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
   parameter int HC_W  = 10,
   parameter int PH_W  = 2,
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             v_vis,
   input  logic [PH_W-1:0]  cpp_last,
   input  logic [HC_W-1:0]  h_last,
   input  logic [HC_W-1:0]  h_sync_w,
   input  logic [HC_W-1:0]  h_de_beg,
   input  logic [HC_W-1:0]  h_de_end,
   output logic             h_sync_act,
   output logic             line_end,
   output logic             de,
   output logic [PH_W-1:0]  pix_phase,
   output logic [COL_W-1:0] col
);
   logic [HC_W-1:0]  hcnt;
   logic [PH_W-1:0]  phase_q;
   logic [COL_W-1:0] col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hcnt <= '0;
      else if (!run)           hcnt <= '0;
      else if (hcnt == h_last) hcnt <= '0;
      else                     hcnt <= hcnt + HC_W'(1);
   end

   assign h_sync_act = run && (hcnt < h_sync_w);
   assign line_end   = run && (hcnt == h_last);
   assign de         = run && v_vis && (hcnt >= h_de_beg) && (hcnt < h_de_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         col_q   <= '0;
      end else if (!de) begin
         phase_q <= '0;
         col_q   <= '0;
      end else if (phase_q == cpp_last) begin
         phase_q <= '0;
         col_q   <= col_q + COL_W'(1);
      end else begin
         phase_q <= phase_q + PH_W'(1);
      end
   end

   assign pix_phase = de ? phase_q : '0;
   assign col       = de ? col_q   : '0;
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
   parameter int V_VISIBLE = 240,
   parameter int V_BLANK   = 4,
   parameter int LN_W      = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            line_end,
   input  logic            h_sync_act,
   output logic            v_vis,
   output logic            v_sync_act,
   output logic            frame_end,
   output logic [LN_W-1:0] line
);
   localparam int V_TOTAL = V_VISIBLE + V_BLANK;
   localparam logic [LN_W-1:0] V_LAST = LN_W'(V_TOTAL - 1);

   logic [LN_W-1:0] vcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vcnt <= '0;
      else if (!run)     vcnt <= '0;
      else if (line_end) vcnt <= (vcnt == V_LAST) ? '0 : vcnt + LN_W'(1);
   end

   assign frame_end  = line_end && (vcnt == V_LAST);
   assign v_vis      = run && (vcnt < LN_W'(V_VISIBLE));
   assign v_sync_act = h_sync_act && (vcnt == '0);
   assign line       = run ? vcnt : '0;
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
   import lcd_sync_pkg::*;
#(
   parameter int H_TOTAL   = 336,
   parameter int H_ACTIVE  = 320,
   parameter int H_SYNC    = 2,
   parameter int H_START   = 7,
   parameter int CORR_X1   = 0,
   parameter int CORR_X2   = 3,
   parameter int CORR_X3   = 5,
   parameter int V_VISIBLE = 240,
   parameter int V_BLANK   = 4,
   parameter int HC_W      = $clog2(H_TOTAL * MAX_CPP + 1),
   parameter int PH_W      = $clog2(MAX_CPP),
   parameter int COL_W     = $clog2(H_ACTIVE + 1),
   parameter int LN_W      = $clog2(V_VISIBLE + V_BLANK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       mode,
   output logic             hsync_n,
   output logic             vsync_n,
   output logic             de,
   output logic [PH_W-1:0]  pix_phase,
   output logic [COL_W-1:0] col,
   output logic [LN_W-1:0]  line
);
   for (genvar k = 1; k <= MAX_CPP; k++) begin : g_chk_mode
      localparam int CORR = (k == 1) ? CORR_X1 : (k == 2) ? CORR_X2 : CORR_X3;
      if ((H_START + H_ACTIVE) * k + CORR > H_TOTAL * k) begin : g_bad_window
         $error("active window overruns the line for a clocks-per-pixel factor");
      end
   end
   if (H_SYNC >= H_START) begin : g_bad_sync
      $error("line sync must end before the active window begins");
   end
   if (V_VISIBLE < 1 || V_BLANK < 0) begin : g_bad_frame
      $error("frame needs at least one visible line");
   end

   logic            run, line_end, frame_end, h_sync_act, v_sync_act, v_vis;
   logic [PH_W-1:0] cpp_last;
   logic [HC_W-1:0] h_last, h_sync_w, h_de_beg, h_de_end;

   lcd_mode_ctrl #(
      .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .H_SYNC(H_SYNC), .H_START(H_START),
      .CORR_X1(CORR_X1), .CORR_X2(CORR_X2), .CORR_X3(CORR_X3),
      .HC_W(HC_W), .PH_W(PH_W)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .en(en), .mode_in(mode), .frame_end(frame_end),
      .run(run), .cpp_last(cpp_last), .h_last(h_last), .h_sync_w(h_sync_w),
      .h_de_beg(h_de_beg), .h_de_end(h_de_end)
   );

   lcd_line_timer #(.HC_W(HC_W), .PH_W(PH_W), .COL_W(COL_W)) u_line (
      .clk(clk), .rst_n(rst_n), .run(run), .v_vis(v_vis), .cpp_last(cpp_last),
      .h_last(h_last), .h_sync_w(h_sync_w), .h_de_beg(h_de_beg), .h_de_end(h_de_end),
      .h_sync_act(h_sync_act), .line_end(line_end), .de(de),
      .pix_phase(pix_phase), .col(col)
   );

   lcd_frame_timer #(.V_VISIBLE(V_VISIBLE), .V_BLANK(V_BLANK), .LN_W(LN_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end), .h_sync_act(h_sync_act),
      .v_vis(v_vis), .v_sync_act(v_sync_act), .frame_end(frame_end), .line(line)
   );

   assign hsync_n = ~h_sync_act;
   assign vsync_n = ~v_sync_act;
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
   parameter int PH_W  = 2,
   parameter int COL_W = 9,
   parameter int LN_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             hsync_n,
   input logic             vsync_n,
   input logic             de,
   input logic [PH_W-1:0]  pix_phase,
   input logic [COL_W-1:0] col,
   input logic [LN_W-1:0]  line
);
   AST_DE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> hsync_n); // R3

   AST_VS_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> (!hsync_n && line == '0)); // R4

   AST_PHASE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      pix_phase < PH_W'(3)); // R5

   AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (pix_phase == '0 && col == '0)); // R5

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (de && $past(de) && pix_phase != '0) |-> (pix_phase == $past(pix_phase) + 1'b1)); // R5

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (de && $past(de)) |-> (col == $past(col) || col == $past(col) + 1'b1)); // R5

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (line != $past(line)) |-> (line == '0 || line == $past(line) + 1'b1)); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (hsync_n && vsync_n && !de && line == '0)); // R9
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.PH_W(PH_W), .COL_W(COL_W), .LN_W(LN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .hsync_n(hsync_n), .vsync_n(vsync_n),
   .de(de), .pix_phase(pix_phase), .col(col), .line(line)
);

// File: tb/sim_lcd_sync_gen.sv
`timescale 1ns/1ps
module sim_lcd_sync_gen;
   localparam int VVIS  = 6;
   localparam int VBLK  = 2;
   localparam int VTOT  = VVIS + VBLK;
   localparam int PH_W  = 2;
   localparam int COL_W = 9;
   localparam int LN_W  = 3;
   // mode, line period, sync width, window start, window length
   localparam int VEC [3][5] = '{
      '{0,  336, 2,  7, 320},
      '{1,  672, 4, 17, 640},
      '{2, 1008, 6, 26, 960}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [1:0] mode = 2'd0;
   logic hsync_n, vsync_n, de;
   logic [PH_W-1:0]  pix_phase;
   logic [COL_W-1:0] col;
   logic [LN_W-1:0]  line;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lcd_sync_gen #(.V_VISIBLE(VVIS), .V_BLANK(VBLK)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .hsync_n(hsync_n),
      .vsync_n(vsync_n), .de(de), .pix_phase(pix_phase), .col(col), .line(line)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic bit quiet();
      return hsync_n && vsync_n && !de && pix_phase == 0 && col == 0 && line == 0;
   endfunction

   task automatic restart(input logic [1:0] m);
      rst_n = 1'b0; en = 1'b0; mode = m;
      step(); step();
      rst_n = 1'b1;
      step();
      en = 1'b1;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      step();
      chk(quiet(), "R9 reset state quiet", int'(quiet()), 1);

      for (int v = 0; v < 3; v++) begin
         int m, ht, hsw, hs, ha, cpp;
         int eh, ev, ed, ep, ec, el, blank_de, n;
         m = VEC[v][0]; ht = VEC[v][1]; hsw = VEC[v][2]; hs = VEC[v][3]; ha = VEC[v][4];
         cpp = ha / 320;
         eh = 0; ev = 0; ed = 0; ep = 0; ec = 0; el = 0; blank_de = 0;
         restart(2'(m));
         for (int i = 0; i < 2 * ht; i++) begin
            int hp, ln;
            bit xde;
            hp = i % ht; ln = i / ht;
            xde = (hp >= hs) && (hp < hs + ha);
            if (hsync_n != !(hp < hsw)) eh++;
            if (vsync_n != !(ln == 0 && hp < hsw)) ev++;
            if (de != xde) ed++;
            if (int'(pix_phase) != (xde ? (hp - hs) % cpp : 0)) ep++;
            if (int'(col) != (xde ? (hp - hs) / cpp : 0)) ec++;
            if (int'(line) != ln) el++;
            step();
         end
         chk(eh == 0, $sformatf("R1 R2 hsync timing mode %0d mismatches", m), eh, 0);
         chk(ev == 0, $sformatf("R4 vsync timing mode %0d mismatches", m), ev, 0);
         chk(ed == 0, $sformatf("R3 de window mode %0d mismatches", m), ed, 0);
         chk(ep == 0 && ec == 0, $sformatf("R5 phase/col mode %0d mismatches", m), ep + ec, 0);
         chk(el == 0, $sformatf("R6 line index mode %0d mismatches", m), el, 0);
         n = 2 * ht;
         while (vsync_n && n < 20000) begin
            if (de && int'(line) >= VVIS) blank_de++;
            step();
            n++;
         end
         chk(n == ht * VTOT, $sformatf("R4 frame length mode %0d", m), n, ht * VTOT);
         chk(blank_de == 0, "R3 de in blanking lines", blank_de, 0);
      end

      // R7: mode change mid-frame waits for the frame boundary
      restart(2'd0);
      for (int i = 0; i < 100; i++) step();
      mode = 2'd1;
      for (int i = 100; i < 336; i++) step();
      chk(hsync_n == 1'b0, "R7 old period kept (sync at 336)", int'(hsync_n), 0);
      step(); step();
      chk(hsync_n == 1'b1, "R7 old sync width kept", int'(hsync_n), 1);
      for (int i = 338; i < 336 * VTOT + 3; i++) step();
      chk(vsync_n == 1'b0, "R7 new sync width after boundary", int'(vsync_n), 0);
      for (int i = 336 * VTOT + 3; i < 336 * VTOT + 336; i++) step();
      chk(hsync_n == 1'b1, "R7 old period gone after boundary", int'(hsync_n), 1);
      for (int i = 336 * VTOT + 336; i < 336 * VTOT + 672; i++) step();
      chk(hsync_n == 1'b0 && line == 3'd1, "R7 new period after boundary", int'(line), 1);

      // R8: reserved mode keeps outputs quiet, then a valid mode starts at once
      begin
         int bad;
         bad = 0;
         restart(2'd3);
         for (int i = 0; i < 400; i++) begin
            if (!quiet()) bad++;
            step();
         end
         chk(bad == 0, "R8 reserved mode quiet cycles", bad, 0);
         mode = 2'd0;
         step();
         chk(hsync_n == 1'b0 && vsync_n == 1'b0, "R8 start after valid mode",
             int'({hsync_n, vsync_n}), 0);
         step(); step();
         chk(hsync_n == 1'b1, "R8 mode 0 sync width", int'(hsync_n), 1);
      end

      // R9: enable low holds quiet, re-enable restarts at line 0 position 0
      for (int i = 0; i < 336 + 20; i++) step();
      en = 1'b0;
      step();
      chk(quiet(), "R9 quiet while disabled", int'(quiet()), 1);
      step(); step();
      chk(quiet(), "R9 still quiet", int'(quiet()), 1);
      en = 1'b1;
      step();
      chk(hsync_n == 1'b0 && vsync_n == 1'b0 && line == 0, "R9 restart at frame start",
          int'({hsync_n, vsync_n}), 0);
      for (int i = 0; i < 7; i++) step();
      chk(de == 1'b1 && col == 0 && pix_phase == 0, "R9 R3 first pixel at position 7",
          int'(de), 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule